// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block orders two unsigned words made of 4-bit digits. The digits may be plain binary or 8421 BCD, and both codes order the same way. Each 4-bit slice looks at its own digit pair from the top bit down. The first bit position where the operands differ decides the result. If the digits are equal, the slice takes its result from a less-significant neighbour through three cascade inputs. The slice drives three result flags: below, same and above.

The top module places `NUM_SLICES` slices in a chain. The least significant digit comes first, and each slice passes its flags to the cascade inputs of the next slice up. The top also takes cascade inputs from outside, so one top can extend another top. For a single standalone comparison, tie the cascade inputs to below=0, same=1, above=0.

The above cascade input has no effect anywhere. When the words are equal, the above output is derived from the other two cascade inputs. If the below and same cascade inputs are both high and the words are equal, both the below and same outputs rise together. This case is not reduced to one-hot. The block has no clock and no storage.

Top module: `cmp_chain`

## Requirements
- R1: When the most significant differing bit of the full word has A=1, B=0, the outputs are ltOut=0, eqOut=0, gtOut=1, whatever the cascade inputs are.
- R2: When the most significant differing bit of the full word has A=0, B=1, the outputs are ltOut=1, eqOut=0, gtOut=0, whatever the cascade inputs are.
- R3: With equal words and cascade inputs casLtIn=0, casEqIn=1, only eqOut is high.
- R4: With equal words and casLtIn=1, casEqIn=0, only ltOut is high.
- R5: With equal words and casLtIn=0, casEqIn=0, only gtOut is high.
- R6: With equal words and casLtIn=1, casEqIn=1, ltOut and eqOut are both high and gtOut is low.
- R7: casGtIn has no effect on any output for any value of the other inputs.
- R8: With cascade inputs 0/1/0, a chain of NUM_SLICES slices gives the plain unsigned ordering of the 4*NUM_SLICES-bit words. This holds for BCD digit strings as well.
- R9: The outputs follow the inputs combinationally, with no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aWord | input | 4*NUM_SLICES | Operand A; digit 0 is in bits 3:0 |
| bWord | input | 4*NUM_SLICES | Operand B; same layout as aWord |
| casLtIn | input | 1 | Cascade input: a lower part had A below B |
| casEqIn | input | 1 | Cascade input: lower parts are equal |
| casGtIn | input | 1 | Cascade input: a lower part had A above B; ignored |
| ltOut | output | 1 | A is below B |
| eqOut | output | 1 | A equals B |
| gtOut | output | 1 | A is above B |

## Verification
Two results can appear together. The below flag and the same flag both rise when the operands are equal and both the below and same cascade inputs are high. The bench provokes this in its exhaustive sweep of one slice: all 256 digit pairs meet all eight cascade patterns. It repeats the case on the full chain with random equal words. The bench expects exactly below=1, same=1, above=0 for this pattern. It also expects a decided digit pair to hide this pattern completely. The random chain vectors compare against a plain integer comparison.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int DIGIT_W = 4;

  // Flags exchanged between slices and seen at the top ports.
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmpFlags_t;

  // Strobes from the digit datapath to the cascade control.
  typedef struct packed {
    logic decided;  // some bit pair differs
    logic aHigh;    // at the top differing bit, A holds the 1
  } digitVerdict_t;
endpackage

// File: rtl/cmp_digit_path.sv
module cmp_digit_path
  import cmp_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic [W-1:0]  aDigit,
  input  logic [W-1:0]  bDigit,
  output digitVerdict_t verdict
);
  logic [W-1:0] diffBits;
  assign diffBits = aDigit ^ bDigit;

  // Scan from the top bit; the first difference found wins.
  always_comb begin
    verdict = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (diffBits[i] && !verdict.decided) begin
        verdict.decided = 1'b1;
        verdict.aHigh   = aDigit[i];
      end
    end
  end
endmodule

// File: rtl/cmp_cascade_ctrl.sv
module cmp_cascade_ctrl
  import cmp_pkg::*;
(
  input  digitVerdict_t verdict,
  input  cmpFlags_t     casIn,
  output cmpFlags_t     result
);
  // The above cascade input is deliberately ignored.
  logic unusedCasGt;
  assign unusedCasGt = casIn.gt;

  logic tie;
  assign tie = !verdict.decided;

  always_comb begin
    result.gt = (verdict.decided && verdict.aHigh)  || (tie && !casIn.lt && !casIn.eq);
    result.lt = (verdict.decided && !verdict.aHigh) || (tie && casIn.lt);
    result.eq = tie && casIn.eq;
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
(
  input  logic [DIGIT_W-1:0] aDigit,
  input  logic [DIGIT_W-1:0] bDigit,
  input  cmpFlags_t          casIn,
  output cmpFlags_t          result
);
  digitVerdict_t verdict;

  cmp_digit_path #(.W(DIGIT_W)) u_path (
    .aDigit (aDigit),
    .bDigit (bDigit),
    .verdict(verdict)
  );

  cmp_cascade_ctrl u_ctrl (
    .verdict(verdict),
    .casIn  (casIn),
    .result (result)
  );
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  localparam int WORD_W = NUM_SLICES * DIGIT_W
) (
  input  logic [WORD_W-1:0] aWord,
  input  logic [WORD_W-1:0] bWord,
  input  logic              casLtIn,
  input  logic              casEqIn,
  input  logic              casGtIn,
  output logic              ltOut,
  output logic              eqOut,
  output logic              gtOut
);
  cmpFlags_t link [NUM_SLICES+1];

  assign link[0] = '{lt: casLtIn, eq: casEqIn, gt: casGtIn};

  // Least significant digit first; each slice feeds the next one up.
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cmp_slice u_slice (
      .aDigit(aWord[k*DIGIT_W +: DIGIT_W]),
      .bDigit(bWord[k*DIGIT_W +: DIGIT_W]),
      .casIn (link[k]),
      .result(link[k+1])
    );
  end

  assign ltOut = link[NUM_SLICES].lt;
  assign eqOut = link[NUM_SLICES].eq;
  assign gtOut = link[NUM_SLICES].gt;
endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
  parameter int NUM_SLICES = 2,
  localparam int WORD_W = NUM_SLICES * 4
) (
  input logic [WORD_W-1:0] aWord,
  input logic [WORD_W-1:0] bWord,
  input logic              casLtIn,
  input logic              casEqIn,
  input logic              ltOut,
  input logic              eqOut,
  input logic              gtOut
);
  always_comb begin
    if (!$isunknown({aWord, bWord, casLtIn, casEqIn})) begin
      // R1
      gt_wins_chk: assert (!(aWord > bWord) || {ltOut, eqOut, gtOut} == 3'b001);
      // R2
      lt_wins_chk: assert (!(aWord < bWord) || {ltOut, eqOut, gtOut} == 3'b100);
      // R3
      pass_eq_chk: assert (!(aWord == bWord && !casLtIn && casEqIn) || {ltOut, eqOut, gtOut} == 3'b010);
      // R4
      pass_lt_chk: assert (!(aWord == bWord && casLtIn && !casEqIn) || {ltOut, eqOut, gtOut} == 3'b100);
      // R5
      pass_none_chk: assert (!(aWord == bWord && !casLtIn && !casEqIn) || {ltOut, eqOut, gtOut} == 3'b001);
      // R6
      dual_flag_chk: assert (!(aWord == bWord && casLtIn && casEqIn) || {ltOut, eqOut, gtOut} == 3'b110);
    end
  end
endmodule

bind cmp_chain cmp_chain_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
  .aWord  (aWord),
  .bWord  (bWord),
  .casLtIn(casLtIn),
  .casEqIn(casEqIn),
  .ltOut  (ltOut),
  .eqOut  (eqOut),
  .gtOut  (gtOut)
);

// File: tb/test_cmp_chain.sv
module test_cmp_chain;
  localparam int CHAIN_N = 4;
  localparam int CW = CHAIN_N * 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // single-slice instance
  logic [3:0] sa, sb;
  logic sLt, sEq, sGt, oLt1, oEq1, oGt1;
  // chain instance
  logic [CW-1:0] ca, cb;
  logic cLt, cEq, cGt, oLt, oEq, oGt;

  cmp_chain #(.NUM_SLICES(1)) i_cmp_single (
    .aWord(sa), .bWord(sb), .casLtIn(sLt), .casEqIn(sEq), .casGtIn(sGt),
    .ltOut(oLt1), .eqOut(oEq1), .gtOut(oGt1));

  cmp_chain #(.NUM_SLICES(CHAIN_N)) i_cmp_chain (
    .aWord(ca), .bWord(cb), .casLtIn(cLt), .casEqIn(cEq), .casGtIn(cGt),
    .ltOut(oLt), .eqOut(oEq), .gtOut(oGt));

  // Behavioural reference: {lt,eq,gt}
  function automatic logic [2:0] refCmp(longint unsigned a, longint unsigned b,
                                        logic cl, logic ce);
    if (a > b) return 3'b001;
    if (a < b) return 3'b100;
    if (cl && ce) return 3'b110;
    if (cl) return 3'b100;
    if (ce) return 3'b010;
    return 3'b001;
  endfunction

  function automatic string reqTag(longint unsigned a, longint unsigned b,
                                   logic cl, logic ce);
    if (a > b) return "R1";
    if (a < b) return "R2";
    if (cl && ce) return "R6";
    if (cl) return "R4";
    if (ce) return "R3";
    return "R5";
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got lt/eq/gt=%b expected %b", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R9: watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] prevOut;
    sa = '0; sb = '0; sLt = 1'b0; sEq = 1'b1; sGt = 1'b0;
    ca = '0; cb = '0; cLt = 1'b0; cEq = 1'b1; cGt = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Idle state: equal zero words with a standalone tie-off read as equal (R3)
    check("R3 idle", {oLt1, oEq1, oGt1}, 3'b010);
    check("R3 idle chain", {oLt, oEq, oGt}, 3'b010);

    // Exhaustive single slice: all operand pairs x all cascade patterns
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          sa = 4'(a); sb = 4'(b);
          {sLt, sEq, sGt} = 3'(c);
          #1;
          check(reqTag(a, b, sLt, sEq), {oLt1, oEq1, oGt1}, refCmp(a, b, sLt, sEq));
        end
      end
    end

    // R7: toggling only casGtIn leaves outputs unchanged
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      sa = 4'h7; sb = 4'h7; {sLt, sEq} = 2'(c); sGt = 1'b0;
      #1; prevOut = {oLt1, oEq1, oGt1};
      sGt = 1'b1;
      #1;
      check("R7", {oLt1, oEq1, oGt1}, prevOut);
    end

    // R8: random chain words with standalone tie-off
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      ca = CW'($urandom); cb = CW'($urandom);
      if (n % 5 == 0) cb = ca ^ CW'(1 << ($urandom % CW));
      {cLt, cEq, cGt} = 3'b010;
      #1;
      check("R8", {oLt, oEq, oGt}, refCmp(ca, cb, 1'b0, 1'b1));
    end

    // R8: BCD digit strings, boundary neighbours
    begin
      logic [CW-1:0] bcdA [4] = '{16'h9999, 16'h1000, 16'h0909, 16'h5000};
      logic [CW-1:0] bcdB [4] = '{16'h9998, 16'h0999, 16'h0990, 16'h5000};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        ca = bcdA[k]; cb = bcdB[k]; {cLt, cEq, cGt} = 3'b010;
        #1;
        check("R8 bcd", {oLt, oEq, oGt}, refCmp(ca, cb, 1'b0, 1'b1));
      end
    end

    // Random chain with random cascade inputs; equal words exercise R6 etc.
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      ca = CW'($urandom);
      cb = (n % 2 == 0) ? ca : CW'($urandom);
      {cLt, cEq, cGt} = 3'($urandom);
      #1;
      check(reqTag(ca, cb, cLt, cEq), {oLt, oEq, oGt}, refCmp(ca, cb, cLt, cEq));
    end

    // R9: outputs follow inputs within the same cycle, no retained state
    @(negedge clk);
    ca = 16'h1234; cb = 16'h1235; {cLt, cEq, cGt} = 3'b010;
    #1; check("R9 first", {oLt, oEq, oGt}, 3'b100);
    ca = 16'h1236;
    #1; check("R9 flip", {oLt, oEq, oGt}, 3'b001);
    cb = 16'h1236;
    #1; check("R9 tie", {oLt, oEq, oGt}, 3'b010);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule